// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the clock line of an I2C master from a fast functional clock. A 16-bit divider value sets the length of one count unit. Each SCL period is built from whole units: two in standard mode, three in fast and fast-plus mode. Each low phase produces a single data-launch strobe. This strobe tells the SDA shifter outside the block when it may change the data line, after a programmable setup delay counted from the falling edge of SCL.

The block also watches the SCL line it has released. If a target device holds the line low, the high phase does not start. It begins only on the first cycle in which SCL is seen high, and from there it runs for a full unit. The divider, mode and setup values are sampled on entry to each low phase. A period therefore never mixes two settings. The `scl_in` input is expected to be already synchronized to `clk`.

Top module: `scl_timing_gen`

## Requirements
- R1: The unit length is `baud_cfg[15:0]` functional-clock cycles, and a value of zero is used as one; `baud_cfg[31:16]` has no effect on timing.
- R2: With `speed_mode` = 0 (standard), SCL is driven low for one unit and then released for one unit.
- R3: With `speed_mode` = 1 (fast) or 3 (fast-plus), SCL is driven low for two units and released for one unit.
- R4: With `speed_mode` = 2, timing falls back to the standard split of R2.
- R5: The setup count is `setup_cfg[31:16]` (bits 15:0 are ignored). `data_launch` pulses exactly once per low phase. The pulse falls in the low cycle with index setup+1, where the first low cycle (the one flagged by `scl_fall_stb`) is index 0.
- R6: When setup+1 is not below the low-phase length, `data_launch` pulses on the last low cycle instead.
- R7: When SCL is released but `scl_in` reads low, `stretch_active` is high and SCL stays released. The high-phase count begins only once `scl_in` is high, and the high phase then lasts a full unit. `scl_rise_stb` marks its first cycle, once per period.
- R8: While `enable` is low, from the next cycle on, SCL is released and no strobe is issued. The first clock edge with `enable` high starts a low phase.
- R9: During reset, SCL is released and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Peripheral enable; low holds the generator idle |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 high-speed (falls back to standard), 3 fast-plus |
| baud_cfg | input | 32 | Bits 15:0 unit length in cycles; bits 31:16 unused |
| setup_cfg | input | 32 | Bits 31:16 data setup count; bits 15:0 unused |
| scl_in | input | 1 | Synchronized level of the SCL line |
| scl_low | output | 1 | 1 = pull SCL low, 0 = release |
| scl_fall_stb | output | 1 | First cycle of a low phase |
| scl_rise_stb | output | 1 | First cycle SCL is seen high in a high phase |
| data_launch | output | 1 | One-cycle strobe allowing SDA to change |
| stretch_active | output | 1 | SCL released but held low by another device |

## Verification
The assertions watch, on every cycle, several local rules. A stretched line never returns to a driven low, and the high-phase counter stays frozen during a stretch. Disabling forces idle on the next edge, the low-phase counter stays inside its window, the unit length is never zero, and a launch strobe never lasts two cycles. Only the bench scenarios can show the actual phase lengths for each mode and divider value, the fallback of the high-speed code, and that the unused register halves are ignored. They also show where the launch strobe lands and when it is clamped, and how many cycles a stretch adds to one period.

// File: rtl/scl_tim_pkg.sv
package scl_tim_pkg;

  localparam int FIELD_W = 16;
  localparam int CNT_W   = FIELD_W + 1;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Unit length in cycles; a zero divider is used as one.
  function automatic logic [CNT_W-1:0] unit_cycles(input logic [FIELD_W-1:0] baud);
    unit_cycles = (baud == '0) ? CNT_W'(1) : {1'b0, baud};
  endfunction

  // Number of units in the low phase for a given speed code.
  function automatic logic [1:0] low_units(input logic [1:0] mode);
    case (mode)
      2'd1, 2'd3: low_units = 2'd2;
      default:    low_units = 2'd1;
    endcase
  endfunction

  // Low phase length in cycles; unit never exceeds 16 significant bits.
  function automatic logic [CNT_W-1:0] low_cycles(input logic [CNT_W-1:0] unit,
                                                  input logic [1:0] units);
    low_cycles = (units == 2'd2) ? {unit[CNT_W-2:0], 1'b0} : unit;
  endfunction

  // Index of the launch cycle inside the low phase, clamped to the last cycle.
  function automatic logic [CNT_W-1:0] launch_index(input logic [FIELD_W-1:0] setup,
                                                    input logic [CNT_W-1:0] low_len);
    logic [CNT_W-1:0] want;
    logic [CNT_W-1:0] last;
    want = {1'b0, setup} + CNT_W'(1);
    last = low_len - CNT_W'(1);
    launch_index = (want < last) ? want : last;
  endfunction

endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
  import scl_tim_pkg::*;
(
  input  logic [1:0]       speed_mode,
  input  logic [31:0]      baud_cfg,
  input  logic [31:0]      setup_cfg,
  output logic [CNT_W-1:0] unit_len,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] launch_idx
);

  logic [FIELD_W-1:0] baud_lo;
  logic [FIELD_W-1:0] setup_hi;
  logic               unused_fields;

  assign baud_lo       = baud_cfg[FIELD_W-1:0];
  assign setup_hi      = setup_cfg[31:FIELD_W];
  assign unused_fields = ^{baud_cfg[31:FIELD_W], setup_cfg[FIELD_W-1:0]};

  assign unit_len   = unit_cycles(baud_lo);
  assign low_len    = low_cycles(unit_len, low_units(speed_mode));
  assign launch_idx = launch_index(setup_hi, low_len);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_tim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] unit_len,
  input  logic [CNT_W-1:0] low_len,
  output phase_e           phase,
  output logic             enter_low,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             stretch
);

  phase_e           phase_q, phase_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] unit_q, low_q;
  logic             low_done, high_done;

  assign low_done  = (cnt_q == low_q - CNT_W'(1));
  assign high_done = scl_in && (cnt_q == unit_q - CNT_W'(1));

  always_comb begin
    phase_n   = phase_q;
    cnt_n     = cnt_q;
    enter_low = 1'b0;
    if (!enable) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          phase_n   = PH_LOW;
          cnt_n     = '0;
          enter_low = 1'b1;
        end
        PH_LOW: begin
          if (low_done) begin
            phase_n = PH_HIGH;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (high_done) begin
            phase_n   = PH_LOW;
            cnt_n     = '0;
            enter_low = 1'b1;
          end else if (scl_in) begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
        default: begin
          phase_n = PH_IDLE;
          cnt_n   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      unit_q  <= CNT_W'(1);
      low_q   <= CNT_W'(1);
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      if (enter_low) begin
        unit_q <= unit_len;
        low_q  <= low_len;
      end
    end
  end

  assign phase    = phase_q;
  assign fall_stb = (phase_q == PH_LOW) && (cnt_q == '0);
  assign rise_stb = (phase_q == PH_HIGH) && (cnt_q == '0) && scl_in;
  assign stretch  = (phase_q == PH_HIGH) && !scl_in;

  AST_STRETCH_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    stretch |=> (phase_q != PH_LOW)); // R7
  AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch && enable) |=> (cnt_q == $past(cnt_q))); // R7
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase_q == PH_IDLE && cnt_q == '0)); // R8
  AST_LOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (cnt_q < low_q)); // R2

endmodule

// File: rtl/scl_setup_timer.sv
module scl_setup_timer
  import scl_tim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic             enter_low,
  input  logic [CNT_W-1:0] launch_idx,
  output logic             launch
);

  logic [CNT_W-1:0] stp_q;
  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stp_q <= '0;
      idx_q <= '0;
    end else if (enter_low) begin
      stp_q <= '0;
      idx_q <= launch_idx;
    end else if (phase == PH_LOW && stp_q != '1) begin
      stp_q <= stp_q + CNT_W'(1);
    end
  end

  assign launch = (phase == PH_LOW) && (stp_q == idx_q);

  AST_SINGLE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch); // R5

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [1:0]  speed_mode,
  input  logic [31:0] baud_cfg,
  input  logic [31:0] setup_cfg,
  input  logic        scl_in,
  output logic        scl_low,
  output logic        scl_fall_stb,
  output logic        scl_rise_stb,
  output logic        data_launch,
  output logic        stretch_active
);

  logic [CNT_W-1:0] unit_len, low_len, launch_idx;
  phase_e           phase;
  logic             enter_low;

  scl_cfg_decode u_decode (
    .speed_mode (speed_mode),
    .baud_cfg   (baud_cfg),
    .setup_cfg  (setup_cfg),
    .unit_len   (unit_len),
    .low_len    (low_len),
    .launch_idx (launch_idx)
  );

  scl_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .scl_in    (scl_in),
    .unit_len  (unit_len),
    .low_len   (low_len),
    .phase     (phase),
    .enter_low (enter_low),
    .fall_stb  (scl_fall_stb),
    .rise_stb  (scl_rise_stb),
    .stretch   (stretch_active)
  );

  scl_setup_timer u_setup (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .enter_low  (enter_low),
    .launch_idx (launch_idx),
    .launch     (data_launch)
  );

  assign scl_low = (phase == PH_LOW);

  AST_UNIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unit_len != '0); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall_stb && scl_rise_stb)); // R7

endmodule

// File: tb/sim_scl_timing_gen.sv
`timescale 1ns/1ps
module sim_scl_timing_gen;

  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  speed_mode = 2'd0;
  logic [31:0] baud_cfg = 32'd4;
  logic [31:0] setup_cfg = 32'd0;
  logic        slave_hold = 1'b0;
  logic        scl_in;
  logic        scl_low, scl_fall_stb, scl_rise_stb, data_launch, stretch_active;

  int tests = 0;
  int fails = 0;
  int stretch_k = 0;
  bit done = 1'b0;

  always #(HALF) clk = ~clk;

  assign scl_in = !scl_low && !slave_hold;

  scl_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .speed_mode(speed_mode),
    .baud_cfg(baud_cfg), .setup_cfg(setup_cfg), .scl_in(scl_in),
    .scl_low(scl_low), .scl_fall_stb(scl_fall_stb), .scl_rise_stb(scl_rise_stb),
    .data_launch(data_launch), .stretch_active(stretch_active)
  );

  // Target device model: holds SCL low for stretch_k cycles after release.
  initial begin
    int left;
    left = 0;
    forever begin
      @(posedge clk);
      #1;
      if (scl_low) begin
        left = stretch_k;
        slave_hold = (stretch_k > 0);
      end else if (left > 0) begin
        slave_hold = 1'b1;
        left--;
      end else begin
        slave_hold = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Waits past the fall in progress, then measures the next full period.
  task automatic measure(output int lo, output int hi, output int li,
                         output int st, output int rises);
    int g;
    g = 0;
    while (!scl_fall_stb && g < 5000) begin @(negedge clk); g++; end
    @(negedge clk);
    while (!scl_fall_stb && g < 5000) begin @(negedge clk); g++; end
    lo = 0; hi = 0; li = -1; st = 0; rises = 0;
    while (scl_low && g < 5000) begin
      if (data_launch) li = lo;
      lo++;
      @(negedge clk); g++;
    end
    while (!scl_low && g < 5000) begin
      if (stretch_active) st++; else hi++;
      if (scl_rise_stb) rises++;
      @(negedge clk); g++;
    end
  endtask

  task automatic run_cfg(input string req, input logic [1:0] mode,
                         input logic [31:0] baud, input logic [31:0] setup,
                         input int exp_lo, input int exp_hi, input int exp_li);
    int lo, hi, li, st, rs;
    speed_mode = mode;
    baud_cfg   = baud;
    setup_cfg  = setup;
    measure(lo, hi, li, st, rs);
    chk({req, " low length"}, lo, exp_lo);
    chk({req, " high length"}, hi, exp_hi);
    chk({req, " launch index"}, li, exp_li);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 scl_low in reset", int'(scl_low), 0);
    chk("R9 strobes in reset", int'(scl_fall_stb | scl_rise_stb | data_launch), 0);
  endtask

  task automatic t_modes;
    run_cfg("R2 std baud4 setup1", 2'd0, 32'd4, {16'd1, 16'd0}, 4, 4, 2);
    run_cfg("R3 fast baud3 setup0", 2'd1, 32'd3, 32'd0, 6, 3, 1);
    run_cfg("R3 fast-plus baud5 setup3", 2'd3, 32'd5, {16'd3, 16'd0}, 10, 5, 4);
    run_cfg("R4 high-speed code fallback", 2'd2, 32'd3, 32'd0, 3, 3, 1);
  endtask

  task automatic t_baud_fields;
    run_cfg("R1 upper baud half ignored", 2'd0, 32'hFFFF_0004, {16'd1, 16'd0}, 4, 4, 2);
    run_cfg("R1 zero baud as one", 2'd0, 32'd0, 32'd0, 1, 1, 0);
  endtask

  task automatic t_setup;
    run_cfg("R5 setup low half ignored", 2'd0, 32'd6, 32'h0001_FFFF, 6, 6, 2);
    run_cfg("R6 setup clamped to last low", 2'd0, 32'd4, {16'd20, 16'd0}, 4, 4, 3);
    run_cfg("R6 fast setup clamp", 2'd1, 32'd2, {16'd3, 16'd0}, 4, 2, 3);
  endtask

  task automatic t_stretch;
    int lo, hi, li, st, rs;
    speed_mode = 2'd0; baud_cfg = 32'd4; setup_cfg = {16'd1, 16'd0};
    stretch_k = 3;
    measure(lo, hi, li, st, rs);
    stretch_k = 0;
    chk("R7 stretch cycles", st, 3);
    chk("R7 high length after stretch", hi, 4);
    chk("R7 one rise strobe", rs, 1);
    chk("R7 low length unaffected", lo, 4);
  endtask

  task automatic t_disable;
    int seen;
    seen = 0;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      seen += int'(scl_low | scl_fall_stb | scl_rise_stb | data_launch);
      @(negedge clk);
    end
    chk("R8 quiet while disabled", seen, 0);
    enable = 1'b1;
    @(negedge clk);
    chk("R8 fall on first enabled edge", int'(scl_fall_stb), 1);
    chk("R8 scl driven low after enable", int'(scl_low), 1);
  endtask

  initial begin
    #(1000000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    enable = 1'b1;
    t_modes();
    t_baud_fields();
    t_setup();
    t_stretch();
    t_disable();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule